// File: doc/BRIEF.md
# Switchable-Order Sinc Decimator with Gain and Offset Trim

This block turns the one-bit feedback stream of a sigma-delta servo loop into signed multi-bit samples. A cascaded integrator-comb filter with a selectable order (second or third) and a selectable decimation ratio (16 or 32) averages the stream. Its result then passes through a trim stage that scales it by an unsigned fixed-point gain, adds a signed offset, and either saturates or wraps the sum into a 16-bit output word.

The bitstream arrives as a data bit qualified by a valid strobe, so the filter advances only on qualified bits and may be fed at any average rate. Filter settings may change while data flows. A change restarts the filter from a clean state and suppresses the first sample produced afterwards, because that sample would mix data from two settings. Gain, offset and clip enable are sampled each time a filter result enters the trim stage. Gain and offset each arrive as a low byte and a high byte.

Top module: `sincdec_top`

## Requirements
- R1: Each qualified input bit counts as +1 when it is 1 and as -1 when it is 0, so a stream of all ones gives a positive full-scale filter result and a stream of all zeros gives the negative one.
- R2: `order_sel` picks the filter order: 0 selects second order and 1 selects third order. The steady-state filter result for a constant mean input m (in [-1,+1]) is m·R^N, where N is the order.
- R3: `dec_sel` picks the ratio R: 0 means one result per 16 qualified bits and 1 means one result per 32 qualified bits. The filter result holds the exact value R^N·m, up to and including +32768 for third order and R=32, without internal overflow.
- R4: When `order_sel` or `dec_sel` differs from its value in the previous cycle, the filter state and the bit count are cleared and that cycle's input bit is discarded. The first result after the change is suppressed, so the first `sample_vld` follows the 2R-th qualified bit after the change.
- R5: Gain is the unsigned Q8.8 value {`gain_hi`,`gain_lo`} (0x0100 = 1.0). The product of filter result and gain is shifted right by 8 bits arithmetically, which rounds toward minus infinity.
- R6: Offset is the two's-complement value {`offset_hi`,`offset_lo`}, added after the gain scaling.
- R7: With `clip_en` = 1, a scaled-and-offset result above 32767 gives 32767 and one below -32768 gives -32768.
- R8: With `clip_en` = 0, the output is the low 16 bits of the scaled-and-offset result.
- R9: During and right after reset, `sample_vld` is 0 and `sample_out` is 0.
- R10: A cycle with `bit_vld` = 0 leaves the filter state unchanged, so idle gaps between qualified bits do not alter the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_in | input | 1 | Bitstream data bit |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| order_sel | input | 1 | 0: second order, 1: third order |
| dec_sel | input | 1 | 0: ratio 16, 1: ratio 32 |
| gain_lo | input | 8 | Gain, fractional byte |
| gain_hi | input | 8 | Gain, integer byte |
| offset_lo | input | 8 | Offset, low byte |
| offset_hi | input | 8 | Offset, high byte (sign in bit 7) |
| clip_en | input | 1 | 1: saturate, 0: wrap |
| sample_out | output | 16 | Signed output sample |
| sample_vld | output | 1 | One-cycle pulse marking a new `sample_out` |

## Verification
Two functions can fall in the same cycle: the full-scale filter result and the trim stage's saturation boundary. Third order at ratio 32 with a constant stream of ones makes the filter reach +32768 while the gain is exactly 1.0, so clipping must produce 32767 and wrapping must produce -32768. A large positive offset on a small result does the same from the other direction. Settings changes are checked against the suppressed first sample by counting qualified bits up to the first output pulse, with each result judged against R^N times the mean of a repeating four-bit pattern.

// File: rtl/sincdec_pkg.sv
package sincdec_pkg;
    localparam int ORDER_MAX = 3;
    localparam int LOG2_RMAX = 5;
    localparam int LOG2_RMIN = 4;
    localparam int OUT_W     = 16;
    localparam int GAIN_FRAC = 8;
    // two extra bits: sign plus room for the positive full-scale value R^N
    localparam int ACC_W     = ORDER_MAX * LOG2_RMAX + 2;
endpackage

// File: rtl/sincdec_integ.sv
module sincdec_integ #(
    parameter int NMAX      = sincdec_pkg::ORDER_MAX,
    parameter int LOG2_RMAX = sincdec_pkg::LOG2_RMAX,
    parameter int LOG2_RMIN = sincdec_pkg::LOG2_RMIN,
    parameter int ACC_W     = sincdec_pkg::ACC_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    in_vld,
    input  logic                    in_bit,
    input  logic                    order_sel,
    input  logic                    dec_sel,
    output logic                    tick,
    output logic signed [ACC_W-1:0] integ_out
);
    localparam int PH_W = LOG2_RMAX;

    typedef struct packed {
        logic [NMAX-1:0][ACC_W-1:0] acc;
        logic [PH_W-1:0]            phase;
        logic                       tick;
    } integ_st_t;

    integ_st_t       st_d, st_q;
    logic [PH_W-1:0] last_phase;
    logic [ACC_W-1:0] step;

    always_comb begin
        st_d       = st_q;
        st_d.tick  = 1'b0;
        last_phase = dec_sel ? PH_W'((1 << LOG2_RMAX) - 1) : PH_W'((1 << LOG2_RMIN) - 1);
        step       = in_bit ? ACC_W'(1) : {ACC_W{1'b1}};
        if (clr) begin
            st_d.acc   = '0;
            st_d.phase = '0;
        end else if (in_vld) begin
            st_d.acc[0] = st_q.acc[0] + step;
            for (int k = 1; k < NMAX; k++) begin
                st_d.acc[k] = st_q.acc[k] + st_d.acc[k-1];
            end
            if (st_q.phase == last_phase) begin
                st_d.phase = '0;
                st_d.tick  = 1'b1;
            end else begin
                st_d.phase = st_q.phase + PH_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick      = st_q.tick;
    assign integ_out = order_sel ? $signed(st_q.acc[NMAX-1]) : $signed(st_q.acc[NMAX-2]);

    assert_phase_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> (st_q.phase <= last_phase));

    assert_clear_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.acc == '0 && st_q.phase == '0));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_vld && !clr) |=> $stable(st_q.acc));
endmodule

// File: rtl/sincdec_comb.sv
module sincdec_comb #(
    parameter int NMAX      = sincdec_pkg::ORDER_MAX,
    parameter int LOG2_RMAX = sincdec_pkg::LOG2_RMAX,
    parameter int LOG2_RMIN = sincdec_pkg::LOG2_RMIN,
    parameter int ACC_W     = sincdec_pkg::ACC_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    tick,
    input  logic                    order_sel,
    input  logic                    dec_sel,
    input  logic signed [ACC_W-1:0] integ_in,
    output logic                    filt_vld,
    output logic signed [ACC_W-1:0] filt
);
    typedef struct packed {
        logic [NMAX-1:0][ACC_W-1:0] dly;
        logic [ACC_W-1:0]           filt;
        logic                       vld;
        logic                       drop;
    } comb_st_t;

    comb_st_t                 st_d, st_q;
    logic [NMAX:0][ACC_W-1:0] stage;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        stage[0] = integ_in;
        for (int k = 0; k < NMAX; k++) begin
            stage[k+1] = stage[k] - st_q.dly[k];
        end
        if (clr) begin
            st_d.dly  = '0;
            st_d.drop = 1'b1;
        end else if (tick) begin
            for (int k = 0; k < NMAX; k++) begin
                st_d.dly[k] = stage[k];
            end
            st_d.filt = order_sel ? stage[NMAX] : stage[NMAX-1];
            st_d.vld  = !st_q.drop;
            st_d.drop = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign filt_vld = st_q.vld;
    assign filt     = $signed(st_q.filt);

    // full-scale magnitude for the present settings, used only by the check
    logic signed [ACC_W:0] full_scale;
    logic signed [ACC_W:0] filt_ext;
    always_comb begin
        full_scale = (ACC_W+1)'(1) << ((order_sel ? NMAX : NMAX - 1) *
                                       (dec_sel ? LOG2_RMAX : LOG2_RMIN));
        filt_ext   = {st_q.filt[ACC_W-1], st_q.filt};
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && !clr) |-> (filt_ext <= full_scale && filt_ext >= -full_scale));
endmodule

// File: rtl/sincdec_trim.sv
module sincdec_trim #(
    parameter int ACC_W     = sincdec_pkg::ACC_W,
    parameter int OUT_W     = sincdec_pkg::OUT_W,
    parameter int GAIN_FRAC = sincdec_pkg::GAIN_FRAC
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [ACC_W-1:0] filt,
    input  logic                    filt_vld,
    input  logic [OUT_W-1:0]        gain,
    input  logic [OUT_W-1:0]        offset,
    input  logic                    clip_en,
    output logic [OUT_W-1:0]        sample_out,
    output logic                    sample_vld
);
    localparam int PROD_W = ACC_W + OUT_W + 1;
    localparam int SUM_W  = PROD_W + 1;
    localparam logic signed [SUM_W-1:0] MAXV = (1 <<< (OUT_W - 1)) - 1;
    localparam logic signed [SUM_W-1:0] MINV = -(1 <<< (OUT_W - 1));

    typedef struct packed {
        logic [OUT_W-1:0] out;
        logic             vld;
    } trim_st_t;

    trim_st_t                 st_d, st_q;
    logic signed [PROD_W-1:0] fx, gx, prod, scaled;
    logic signed [SUM_W-1:0]  sum;

    always_comb begin
        fx     = {{(PROD_W-ACC_W){filt[ACC_W-1]}}, filt};
        gx     = {{(PROD_W-OUT_W){1'b0}}, gain};
        prod   = fx * gx;
        scaled = prod >>> GAIN_FRAC;
        sum    = {scaled[PROD_W-1], scaled} + {{(SUM_W-OUT_W){offset[OUT_W-1]}}, offset};
        st_d     = st_q;
        st_d.vld = filt_vld;
        if (filt_vld) begin
            if (clip_en && sum > MAXV)      st_d.out = MAXV[OUT_W-1:0];
            else if (clip_en && sum < MINV) st_d.out = MINV[OUT_W-1:0];
            else                            st_d.out = sum[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sample_out = st_q.out;
    assign sample_vld = st_q.vld;

    assert_clip_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && $past(clip_en) && !$past(filt[ACC_W-1]) && !$past(offset[OUT_W-1]))
        |-> !sample_out[OUT_W-1]);
endmodule

// File: rtl/sincdec_top.sv
module sincdec_top #(
    parameter int ORDER_MAX = sincdec_pkg::ORDER_MAX,
    parameter int LOG2_RMAX = sincdec_pkg::LOG2_RMAX,
    parameter int LOG2_RMIN = sincdec_pkg::LOG2_RMIN,
    parameter int OUT_W     = sincdec_pkg::OUT_W,
    parameter int GAIN_FRAC = sincdec_pkg::GAIN_FRAC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_in,
    input  logic               bit_vld,
    input  logic               order_sel,
    input  logic               dec_sel,
    input  logic [OUT_W/2-1:0] gain_lo,
    input  logic [OUT_W/2-1:0] gain_hi,
    input  logic [OUT_W/2-1:0] offset_lo,
    input  logic [OUT_W/2-1:0] offset_hi,
    input  logic               clip_en,
    output logic [OUT_W-1:0]   sample_out,
    output logic               sample_vld
);
    localparam int ACC_W = ORDER_MAX * LOG2_RMAX + 2;

    typedef struct packed {
        logic order;
        logic dec;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic clr;

    always_comb begin
        cfg_d.order = order_sel;
        cfg_d.dec   = dec_sel;
        clr         = (cfg_d != cfg_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '{order: 1'b1, dec: 1'b1};
        else        cfg_q <= cfg_d;
    end

    logic                    tick;
    logic signed [ACC_W-1:0] integ_val;
    logic                    filt_vld;
    logic signed [ACC_W-1:0] filt;

    sincdec_integ #(
        .NMAX(ORDER_MAX), .LOG2_RMAX(LOG2_RMAX), .LOG2_RMIN(LOG2_RMIN), .ACC_W(ACC_W)
    ) u_integ (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(bit_vld), .in_bit(bit_in),
        .order_sel(order_sel), .dec_sel(dec_sel), .tick(tick), .integ_out(integ_val)
    );

    sincdec_comb #(
        .NMAX(ORDER_MAX), .LOG2_RMAX(LOG2_RMAX), .LOG2_RMIN(LOG2_RMIN), .ACC_W(ACC_W)
    ) u_comb (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .order_sel(order_sel),
        .dec_sel(dec_sel), .integ_in(integ_val), .filt_vld(filt_vld), .filt(filt)
    );

    sincdec_trim #(
        .ACC_W(ACC_W), .OUT_W(OUT_W), .GAIN_FRAC(GAIN_FRAC)
    ) u_trim (
        .clk(clk), .rst_n(rst_n), .filt(filt), .filt_vld(filt_vld),
        .gain({gain_hi, gain_lo}), .offset({offset_hi, offset_lo}), .clip_en(clip_en),
        .sample_out(sample_out), .sample_vld(sample_vld)
    );

    // the result in flight at a settings change may still leave, the one after may not
    assert_drop_after_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> ##2 !sample_vld);
endmodule

// File: tb/sincdec_top_test.sv
module sincdec_top_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, bit_in, bit_vld, order_sel, dec_sel, clip_en;
    logic [15:0] gain, offset;
    logic [15:0] sample_out;
    logic        sample_vld;

    sincdec_top uut (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
        .order_sel(order_sel), .dec_sel(dec_sel),
        .gain_lo(gain[7:0]), .gain_hi(gain[15:8]),
        .offset_lo(offset[7:0]), .offset_hi(offset[15:8]),
        .clip_en(clip_en), .sample_out(sample_out), .sample_vld(sample_vld)
    );

    int    checks = 0, failures = 0, vld_count = 0;
    bit    mon_en = 1'b1;
    int    exp_q[$];
    bit    skip_q[$];
    string tag_q[$];
    int    m_exp;
    bit    m_skip;
    string m_tag;

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && sample_vld) begin
            vld_count++;
            if (mon_en) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected sample", int'($signed(sample_out)), 0);
                end else begin
                    m_exp  = exp_q.pop_front();
                    m_skip = skip_q.pop_front();
                    m_tag  = tag_q.pop_front();
                    if (!m_skip)
                        chk(int'($signed(sample_out)) == m_exp, m_tag,
                            int'($signed(sample_out)), m_exp);
                end
            end
        end
    end

    function automatic int model(longint f, longint g, longint off, bit clip);
        longint    s;
        logic [15:0] w;
        s = ((f * g) >>> 8) + off;
        if (clip) begin
            if (s > 32767)  s = 32767;
            if (s < -32768) s = -32768;
            return int'(s);
        end
        w = s[15:0];
        return int'($signed(w));
    endfunction

    task automatic send(bit b, int gap);
        @(negedge clk);
        bit_in  = b;
        bit_vld = 1'b1;
        @(negedge clk);
        bit_vld = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic restart(bit o, bit d);
        @(negedge clk);
        order_sel = o;
        dec_sel   = ~d;
        @(negedge clk);
        dec_sel = d;
        @(negedge clk);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic segment(bit o, bit d, logic [15:0] g, logic [15:0] off, bit clip,
                           logic [3:0] pat, int gap, string tag);
        int     r, n, ones, expv;
        longint fs;
        r    = d ? 32 : 16;
        n    = o ? 3 : 2;
        fs   = 1;
        for (int i = 0; i < n; i++) fs = fs * r;
        ones = $countones(pat);
        expv = model(fs * (2 * ones - 4) / 4, longint'(g), longint'($signed(off)), clip);
        gain    = g;
        offset  = off;
        clip_en = clip;
        restart(o, d);
        for (int i = 0; i < 4; i++) begin
            exp_q.push_back(0); skip_q.push_back(1'b1); tag_q.push_back(tag);
        end
        for (int i = 0; i < 3; i++) begin
            exp_q.push_back(expv); skip_q.push_back(1'b0); tag_q.push_back(tag);
        end
        for (int i = 0; i < 8 * r; i++) send(pat[i % 4], gap > 0 ? (i % gap) + 1 : 0);
        drain();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R3 watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bit_in = 1'b0; bit_vld = 1'b0;
        order_sel = 1'b1; dec_sel = 1'b1; clip_en = 1'b1;
        gain = 16'h0100; offset = 16'h0000;
        repeat (3) @(negedge clk);
        chk(sample_vld == 1'b0, "R9 reset valid", int'(sample_vld), 0);
        chk(sample_out == 16'h0, "R9 reset sample", int'(sample_out), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        segment(1, 1, 16'h0100, 16'h0000, 1, 4'b1111, 0, "R7 R3 R1 third order ratio 32 ones clipped");
        segment(1, 1, 16'h0100, 16'h0000, 0, 4'b1111, 0, "R8 full-scale ones wrapped");
        segment(1, 1, 16'h0100, 16'h0000, 1, 4'b0000, 0, "R1 full-scale zeros");
        segment(0, 0, 16'h0280, 16'hFF9C, 1, 4'b1111, 0, "R2 R5 R6 second order ratio 16 gain 2.5");
        segment(0, 1, 16'h0100, 16'd1000, 1, 4'b0111, 0, "R3 second order ratio 32 mean half");
        segment(0, 0, 16'h0101, 16'h0000, 1, 4'b0001, 0, "R5 floor on negative product");
        segment(1, 0, 16'h1000, 16'h0000, 1, 4'b0000, 0, "R7 negative saturation");
        segment(1, 0, 16'h1000, 16'h0000, 0, 4'b0000, 0, "R8 negative wrap");
        segment(1, 0, 16'h0100, 16'h0000, 1, 4'b1011, 3, "R10 idle gaps between bits");
        segment(0, 0, 16'h0100, 16'd32700, 1, 4'b1111, 0, "R6 R7 offset pushes over maximum");
        segment(1, 1, 16'hFFFF, 16'h8001, 1, 4'b0101, 0, "R6 zero mean with negative offset");

        // R4: settings change suppresses the first result
        mon_en = 1'b0;
        restart(0, 0);
        vld_count = 0;
        for (int i = 0; i < 31; i++) send(i[0], 0);
        repeat (6) @(negedge clk);
        chk(vld_count == 0, "R4 no sample before 2R bits", vld_count, 0);
        send(1'b1, 0);
        repeat (6) @(negedge clk);
        chk(vld_count == 1, "R4 first sample at 2R bits", vld_count, 1);
        mon_en = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule